// File: doc/BRIEF.md
# Delayed Single-Pulse Sequencer

This block produces one output pulse per power-up. After a power-present level appears, it waits through a long, adjustable delay. It then drives its output high for a shorter, adjustable interval. After that it freezes with a done flag raised until the power-present level goes away.

Timing is measured in ticks. A tick is a one-cycle clock enable that stands in for a slow oscillator. The block has two cascaded prescaled stages.

- The delay stage counts `DELAY_TICKS` ticks. It then latches its stop flag and stays stopped.
- The pulse stage is held cleared until that flag is set. It then counts two half-periods of `PULSE_TICKS` ticks each.
- The output is the half-period bit just below the pulse stage's stop bit. It therefore rises one half-period after the pulse stage starts and falls one half-period later, when the stop bit sets.

The power-present input is asynchronous. It clears a two-flop synchroniser at once, and its rise reaches the counters only after two clock edges. The synchroniser output serves as the asynchronous clear of both stages, so removing power-present returns everything to the reset state immediately.

With the default parameters and a 1 Hz tick, the output rises 300 s after power-present appears (295 s of delay plus one 5 s half-period) and stays high for 5 s.

Top module: `pls_seq`

## Requirements
- R1: While `pwr_ok_i` is low, `pulse_o` and `done_o` are 0. Dropping `pwr_ok_i` forces both to 0 without waiting for a clock edge.
- R2: A rise of `pwr_ok_i` reaches the counters through two synchroniser flops. A tick present at the first or second clock edge after the rise is not counted.
- R3: The delay stage counts exactly `DELAY_TICKS` accepted ticks. It then sets its stop flag and holds it until `pwr_ok_i` falls.
- R4: While the delay stage has not stopped, the pulse stage stays at zero. Any tick that arrives in that time, including the tick that completes the delay, is not counted by the pulse stage.
- R5: `pulse_o` rises at the clock edge of the (`DELAY_TICKS`+`PULSE_TICKS`)-th accepted tick after the power-present rise.
- R6: `pulse_o` falls at the edge of the (`DELAY_TICKS`+2·`PULSE_TICKS`)-th accepted tick, so it stays high for exactly `PULSE_TICKS` ticks. `pulse_o` and `done_o` are never high together.
- R7: `done_o` rises on the same edge that `pulse_o` falls. It stays high until `pwr_ok_i` falls.
- R8: After `done_o` is set, further ticks change neither output.
- R9: A clock edge with `tick_i` low advances neither stage.
- R10: Removing `pwr_ok_i` at any point in the sequence, including before the pulse or during it, abandons the sequence. Re-applying `pwr_ok_i` then runs the full delay again from zero.
- R11: With default parameters (`DELAY_TICKS`=295, `PULSE_TICKS`=5) and a tick on every cycle, `pulse_o` rises at edge 302 after the power-present rise and falls at edge 307.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_ok_i | input | 1 | Asynchronous power-present level; low holds the block in reset |
| tick_i | input | 1 | One-cycle clock enable that stands in for the slow oscillator |
| pulse_o | output | 1 | Delayed single pulse |
| done_o | output | 1 | Sequence finished; high until `pwr_ok_i` falls |

## Verification
Two events can share a clock edge.

The first pair is the tick that completes the delay and the first tick the pulse stage could see. With a tick on every cycle they coincide, and a rise exactly `PULSE_TICKS` edges after the delay ends shows the pulse stage did not take the terminal tick.

The second pair is the loss of power-present and a stage boundary. The stimulus table drops `pwr_ok_i` just before the edge that would stop the delay stage, raise the pulse or raise done. In each case both outputs must read 0 for the rest of that run. A reference model in the bench, driven only by the tick pattern and the power-present level, supplies the expected outputs for every cycle.

// File: rtl/pls_pkg.sv
package pls_pkg;
  // Width of a counter that must hold values 0..n-1, never below one bit.
  function automatic int unsigned cnt_w(input int unsigned n);
    cnt_w = (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pls_sync.sv
// Two-flop synchroniser for an active-high level. Clearing is immediate, release is clocked.
module pls_sync (
  input  logic clk,
  input  logic lvl_i,
  output logic lvl_o
);
  logic stg1;

  always_ff @(posedge clk or negedge lvl_i) begin
    if (!lvl_i) begin
      stg1  <= 1'b0;
      lvl_o <= 1'b0;
    end else begin
      stg1  <= 1'b1;
      lvl_o <= stg1;
    end
  end
endmodule

// File: rtl/pls_stage.sv
// Prescaled stage: a tick prescaler of TERM ticks feeding a half-period counter.
// The counter stops when it reaches HALVES and holds until cleared.
module pls_stage
  import pls_pkg::*;
#(
  parameter int unsigned TERM   = 4,
  parameter int unsigned HALVES = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic                         tick,
  output logic [cnt_w(HALVES+1)-1:0]   half
);
  localparam int unsigned PRE_W  = cnt_w(TERM);
  localparam int unsigned HALF_W = cnt_w(HALVES + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(TERM - 1);
  localparam logic [HALF_W-1:0] HALF_END = HALF_W'(HALVES);

  logic [PRE_W-1:0] pre;
  logic             stopped;
  logic             adv;

  assign stopped = (half == HALF_END);
  assign adv     = run && tick && !stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      half <= '0;
    end else if (adv) begin
      if (pre == PRE_LAST) begin
        pre  <= '0;
        half <= half + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pls_seq.sv
module pls_seq
  import pls_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 295,
  parameter int unsigned PULSE_TICKS = 5
) (
  input  logic clk,
  input  logic pwr_ok_i,
  input  logic tick_i,
  output logic pulse_o,
  output logic done_o
);
  localparam int unsigned DLY_HALVES = 1;
  localparam int unsigned PW_HALVES  = 2;

  logic                            en_sync;
  logic [cnt_w(DLY_HALVES+1)-1:0]  dly_half;
  logic [cnt_w(PW_HALVES+1)-1:0]   pw_half;
  logic                            dly_stop;

  pls_sync u_sync (
    .clk   (clk),
    .lvl_i (pwr_ok_i),
    .lvl_o (en_sync)
  );

  // Delay stage: one half-period of DELAY_TICKS, then its single bit latches.
  pls_stage #(.TERM(DELAY_TICKS), .HALVES(DLY_HALVES)) u_dly (
    .clk   (clk),
    .rst_n (en_sync),
    .run   (1'b1),
    .tick  (tick_i),
    .half  (dly_half)
  );

  assign dly_stop = dly_half[0];

  // Pulse stage: cleared and frozen until the delay stage has stopped.
  pls_stage #(.TERM(PULSE_TICKS), .HALVES(PW_HALVES)) u_pw (
    .clk   (clk),
    .rst_n (en_sync),
    .run   (dly_stop),
    .tick  (tick_i),
    .half  (pw_half)
  );

  // Output is the bit below the stop bit; the stop bit is the done flag.
  assign pulse_o = pw_half[0];
  assign done_o  = pw_half[1];
endmodule

// File: rtl/pls_seq_chk.sv
module pls_seq_chk (
  input logic       clk,
  input logic       pwr_ok,
  input logic       tick,
  input logic       pulse,
  input logic       done,
  input logic       en,
  input logic       dly_stop,
  input logic [1:0] pw_half
);
  p_reset_r1: assert property (@(posedge clk) !pwr_ok |-> (!pulse && !done))
    else $error("R1 outputs active while power absent");

  p_sync_r2: assert property (@(posedge clk) disable iff (!pwr_ok) $rose(en) |-> $past(pwr_ok))
    else $error("R2 enable released without prior power-present");

  p_dly_hold_r3: assert property (@(posedge clk) disable iff (!pwr_ok) dly_stop |=> dly_stop)
    else $error("R3 delay stop flag lost");

  p_pw_frozen_r4: assert property (@(posedge clk) disable iff (!pwr_ok) !dly_stop |-> (pw_half == 2'b00))
    else $error("R4 pulse stage moved during delay");

  p_rise_r5: assert property (@(posedge clk) disable iff (!pwr_ok) $rose(pulse) |-> dly_stop)
    else $error("R5 pulse rose before delay ended");

  p_excl_r6: assert property (@(posedge clk) disable iff (!pwr_ok) !(pulse && done))
    else $error("R6 pulse and done together");

  p_fall_done_r7: assert property (@(posedge clk) disable iff (!pwr_ok) $fell(pulse) |-> done)
    else $error("R7 pulse ended without done");

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!pwr_ok) done |=> done)
    else $error("R7 done dropped while powered");

  p_notick_r9: assert property (@(posedge clk) disable iff (!pwr_ok)
                                (en && !tick) |=> ($stable(pw_half) && $stable(dly_stop)))
    else $error("R9 stage advanced without tick");
endmodule

bind pls_seq pls_seq_chk u_chk (
  .clk      (clk),
  .pwr_ok   (pwr_ok_i),
  .tick     (tick_i),
  .pulse    (pulse_o),
  .done     (done_o),
  .en       (en_sync),
  .dly_stop (dly_stop),
  .pw_half  (pw_half)
);

// File: tb/tb_pls_seq.sv
`timescale 1ns/1ps
module tb_pls_seq;
  localparam int D = 6;
  localparam int P = 3;
  localparam int NV = 8;
  // period, drop cycle (0 = never), cycles to run
  localparam int VEC [NV][3] = '{
    '{1, 0, 30},
    '{2, 0, 50},
    '{3, 0, 70},
    '{5, 0, 90},
    '{1, 8, 25},
    '{1, 11, 25},
    '{1, 14, 25},
    '{2, 20, 40}
  };

  logic clk = 1'b0;
  logic pwr = 1'b0;
  logic tick = 1'b0;
  logic tick_d = 1'b0;
  logic pulse, done, pulse_d, done_d;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pls_seq #(.DELAY_TICKS(D), .PULSE_TICKS(P)) dut (
    .clk(clk), .pwr_ok_i(pwr), .tick_i(tick), .pulse_o(pulse), .done_o(done)
  );

  pls_seq dut_dflt (
    .clk(clk), .pwr_ok_i(pwr), .tick_i(tick_d), .pulse_o(pulse_d), .done_o(done_d)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_case(input int per, input int drop, input int ncyc);
    int acc;
    bit alive;
    bit ep, ed;
    pwr = 1'b0;
    tick = 1'b0;
    repeat (3) @(negedge clk);
    check(pulse == 0 && done == 0, "R1 reset state", {pulse, done}, 0);
    pwr = 1'b1;
    acc = 0;
    alive = 1'b1;
    for (int c = 1; c <= ncyc; c++) begin
      tick = (c % per == 0);
      if (drop == c) begin
        pwr = 1'b0;
        alive = 1'b0;
        #0.5;
        check(pulse == 0 && done == 0, "R1 R10 immediate clear", {pulse, done}, 0);
      end
      @(posedge clk);
      if (alive && c >= 3 && tick && acc < D + 2*P) acc++;
      #1;
      ep = alive && acc >= D + P && acc < D + 2*P;
      ed = alive && acc >= D + 2*P;
      if (ed)
        check(pulse == ep && done == ed, "R6 R7 R8 done hold", {pulse, done}, {ep, ed});
      else if (ep)
        check(pulse == ep && done == ed, "R5 pulse high", {pulse, done}, {ep, ed});
      else if (!alive)
        check(pulse == 0 && done == 0, "R10 abandoned", {pulse, done}, 0);
      else
        check(pulse == 0 && done == 0, "R2 R3 R4 R9 delay phase", {pulse, done}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check(pulse == 0 && done == 0, "R1 initial", {pulse, done}, 0);
    for (int v = 0; v < NV; v++) run_case(VEC[v][0], VEC[v][1], VEC[v][2]);

    // Directed: tick exactly on the first two edges only, then none: nothing counts (R2).
    pwr = 1'b0;
    repeat (3) @(negedge clk);
    pwr = 1'b1;
    tick = 1'b1;
    repeat (2) @(negedge clk);
    tick = 1'b0;
    // D+P-2 more ticks: total accepted D+P-2, pulse must stay low (R2).
    for (int k = 0; k < D + P - 2; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
    check(pulse == 0, "R2 early ticks ignored", pulse, 0);
    // Two more ticks: the (D+P)-th accepted tick raises the pulse (R5).
    tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    check(pulse == 0, "R2 one short", pulse, 0);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    check(pulse == 1, "R5 rise on exact tick", pulse, 1);
    // Long gap with no ticks: pulse frozen (R9).
    repeat (20) @(negedge clk);
    check(pulse == 1 && done == 0, "R9 no tick no advance", {pulse, done}, 2);

    // Default parameters, tick every cycle (R11).
    pwr = 1'b0;
    tick_d = 1'b1;
    repeat (3) @(negedge clk);
    pwr = 1'b1;
    for (int c = 1; c <= 320; c++) begin
      @(posedge clk);
      #1;
      if (c == 301) check(pulse_d == 0, "R11 low before rise", pulse_d, 0);
      if (c == 302) check(pulse_d == 1, "R11 rise at 302", pulse_d, 1);
      if (c == 306) check(pulse_d == 1 && done_d == 0, "R11 high at 306", {pulse_d, done_d}, 2);
      if (c == 307) check(pulse_d == 0 && done_d == 1, "R11 fall at 307", {pulse_d, done_d}, 1);
      if (c == 320) check(pulse_d == 0 && done_d == 1, "R8 R11 hold", {pulse_d, done_d}, 1);
    end
    pwr = 1'b0;
    #1;
    check(pulse_d == 0 && done_d == 0, "R1 R10 default cleared", {pulse_d, done_d}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule